// File: doc/BRIEF.md
# Byte Program-Verify Sequencer

This block sits on the host side of a byte-wide flash device and programs one byte through the device's command interface. A request carries a target address and a data byte. The block then runs a fixed sequence of bus cycles. It writes the program-setup command, then writes the target address with the data byte. It waits out the program pulse, writes the program-verify command, and reads the byte back.

When the read-back byte equals the requested byte, the block finishes successfully. When it differs, the whole sequence runs again, up to a fixed number of attempts. If the last attempt still fails, the block raises an error. In both cases it reports how many attempts were used.

Each bus cycle is built from whole clock periods. For a write, chip enable and the address are driven before the write strobe falls. Output enable stays high during the write. The data driver stays on until after the strobe has risen. During a read, output enable is low and the data driver is off. The block accepts only one request at a time.

Top module: `byte_prog_seq`

## Requirements
- R1: After reset the block is idle: busy, done and error are 0, the attempt count is 0, chip enable, write strobe and output enable are high (inactive), and the data driver enable is 0.
- R2: Each attempt issues exactly three writes and then one read, in this order: command byte 40h, the target byte at the target address, command byte C0h, then a read of the target address.
- R3: While the write strobe is low, and on the cycle it rises, the address and the data driven to the device do not change.
- R4: The write strobe of the verify command falls no earlier than PULSE_CYC clock cycles after the rising strobe edge of the program write. Chip enable stays high for the whole pulse wait.
- R5: The verify read is performed with output enable low, and the byte sampled in its last cycle is the one that gets compared.
- R6: When the read-back byte equals the requested byte, done pulses with error 0, and the attempt count equals the number of program writes issued for this request.
- R7: When MAX_TRIES attempts all mismatch, done pulses with error 1 and the attempt count equals MAX_TRIES. The count never exceeds MAX_TRIES.
- R8: The write strobe is low only while chip enable is low, output enable is high and the data driver is enabled. Chip enable falls at least one cycle before the write strobe.
- R9: The data driver enable is 0 whenever output enable is low.
- R10: A request presented while busy is high is ignored. It causes no bus cycle, and it does not change the address or data of the request in progress.
- R11: Busy rises on the cycle after a request is accepted. Done is a single-cycle pulse, busy is low on the cycle done is high, and busy was high on the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe, sampled when idle |
| req_addr_i | input | ADDR_W | Target byte address |
| req_data_i | input | DATA_W | Byte to program |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request exhausted its attempts |
| attempts_o | output | TRY_W | Attempts used by the current or last request |
| fl_addr_o | output | ADDR_W | Address to the device |
| fl_dout_o | output | DATA_W | Data to the device |
| fl_drv_o | output | 1 | Tri-state enable for the data bus driver |
| fl_din_i | input | DATA_W | Data from the device |
| fl_ce_n_o | output | 1 | Chip enable, active low |
| fl_we_n_o | output | 1 | Write strobe, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |

## Verification
A wrong sequencer state shows up at the device pins within one bus cycle. The symptoms are a command byte out of order, a missing write, or a pulse wait that is too short. A device model in the bench counts each of these on the strobe edge where it happens.

A wrong attempt counter or a wrong compare shows up only at the done pulse. It appears as an error flag or attempt count that differs from a value computed from the model's programming behaviour. That value is set per address by the number of pulses the cell ignores before it takes the data, and by whether the new byte needs any 0 bit turned back to 1.

The sweep covers these cases:
- every address of a small array;
- success on the first attempt and on the last allowed attempt;
- failure after exhausting every attempt;
- a byte that can never verify;
- a stray request injected while busy.

// File: rtl/bps_pkg.sv
package bps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSET,
    PH_WLOW,
    PH_WHLD,
    PH_RACT
  } bus_ph_e;

  typedef enum logic [2:0] {
    T_IDLE,
    T_SETUP,
    T_PROG,
    T_PULSE,
    T_VCMD,
    T_VREAD,
    T_CMP
  } seq_st_e;

  localparam logic [7:0] CMD_PGM_SETUP  = 8'h40;
  localparam logic [7:0] CMD_PGM_VERIFY = 8'hC0;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } bus_ctl_t;

  function automatic bus_ctl_t ctl_of(bus_ph_e p);
    bus_ctl_t c;
    c = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
    case (p)
      PH_WSET, PH_WHLD: begin
        c.ce_n = 1'b0;
        c.drv  = 1'b1;
      end
      PH_WLOW: begin
        c.ce_n = 1'b0;
        c.we_n = 1'b0;
        c.drv  = 1'b1;
      end
      PH_RACT: begin
        c.ce_n = 1'b0;
        c.oe_n = 1'b0;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bps_bus_cycle.sv
module bps_bus_cycle
  import bps_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int SET_CYC = 2,
  parameter int LOW_CYC = 2,
  parameter int HLD_CYC = 1,
  parameter int RD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              drv_o,
  input  logic [DATA_W-1:0] din_i,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o
);

  localparam int CNT_W = $clog2(SET_CYC + LOW_CYC + HLD_CYC + RD_CYC + 1);

  bus_ph_e    ph, nxt_ph;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic       fin;
  bus_ctl_t   ctl;

  always_comb begin
    nxt_ph  = ph;
    nxt_cnt = cnt;
    fin     = 1'b0;
    if (ph == PH_IDLE) begin
      if (start_i) begin
        nxt_ph  = rd_i ? PH_RACT : PH_WSET;
        nxt_cnt = rd_i ? CNT_W'(RD_CYC - 1) : CNT_W'(SET_CYC - 1);
      end
    end else if (cnt != '0) begin
      nxt_cnt = cnt - 1'b1;
    end else begin
      case (ph)
        PH_WSET: begin
          nxt_ph  = PH_WLOW;
          nxt_cnt = CNT_W'(LOW_CYC - 1);
        end
        PH_WLOW: begin
          nxt_ph  = PH_WHLD;
          nxt_cnt = CNT_W'(HLD_CYC - 1);
        end
        default: begin
          nxt_ph = PH_IDLE;
          fin    = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      ctl       <= ctl_of(PH_IDLE);
      done_o    <= 1'b0;
      addr_o    <= '0;
      dout_o    <= '0;
      rd_data_o <= '0;
    end else begin
      ph     <= nxt_ph;
      cnt    <= nxt_cnt;
      ctl    <= ctl_of(nxt_ph);
      done_o <= fin;
      if (ph == PH_IDLE && start_i) begin
        addr_o <= addr_i;
        dout_o <= data_i;
      end
      if (ph == PH_RACT && cnt == '0) rd_data_o <= din_i;
    end
  end

  assign ce_n_o = ctl.ce_n;
  assign we_n_o = ctl.we_n;
  assign oe_n_o = ctl.oe_n;
  assign drv_o  = ctl.drv;

  // R8
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n_o |-> (!ce_n_o && oe_n_o && drv_o));

  // R8
  ce_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n_o) |-> $past(!ce_n_o));

  // R9
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n_o |-> !drv_o);

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n_o || $rose(we_n_o)) |-> ($stable(addr_o) && $stable(dout_o)));

endmodule

// File: rtl/bps_pulse_timer.sv
module bps_pulse_timer #(
  parameter int PULSE_CYC = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);

  localparam int TW = $clog2(PULSE_CYC + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      expired_o <= 1'b1;
    end else if (load_i) begin
      cnt       <= TW'(PULSE_CYC);
      expired_o <= 1'b0;
    end else if (cnt > TW'(1)) begin
      cnt <= cnt - 1'b1;
    end else if (cnt == TW'(1)) begin
      cnt       <= '0;
      expired_o <= 1'b1;
    end
  end

  // R4
  load_clears_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !expired_o);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(PULSE_CYC));

endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
  import bps_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int MAX_TRIES = 25,
  parameter int PULSE_CYC = 1250,
  parameter int SET_CYC   = 2,
  parameter int LOW_CYC   = 2,
  parameter int HLD_CYC   = 1,
  parameter int RD_CYC    = 2,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [TRY_W-1:0]  attempts_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_dout_o,
  output logic              fl_drv_o,
  input  logic [DATA_W-1:0] fl_din_i,
  output logic              fl_ce_n_o,
  output logic              fl_we_n_o,
  output logic              fl_oe_n_o
);

  seq_st_e           state;
  logic              launched;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic [TRY_W-1:0]  tries;

  logic              bus_start, bus_rd, bus_done;
  logic [DATA_W-1:0] bus_data, bus_rd_data;
  logic              tmr_load, tmr_expired;
  logic              on_bus_state;

  assign on_bus_state = (state == T_SETUP) || (state == T_PROG) ||
                        (state == T_VCMD)  || (state == T_VREAD);
  assign bus_start    = on_bus_state && !launched;
  assign bus_rd       = (state == T_VREAD);
  assign tmr_load     = (state == T_PROG) && bus_done;

  always_comb begin
    case (state)
      T_SETUP: bus_data = DATA_W'(CMD_PGM_SETUP);
      T_PROG:  bus_data = d_q;
      default: bus_data = DATA_W'(CMD_PGM_VERIFY);
    endcase
  end

  bps_bus_cycle #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SET_CYC(SET_CYC),
    .LOW_CYC(LOW_CYC),
    .HLD_CYC(HLD_CYC),
    .RD_CYC (RD_CYC)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .start_i  (bus_start),
    .rd_i     (bus_rd),
    .addr_i   (a_q),
    .data_i   (bus_data),
    .done_o   (bus_done),
    .rd_data_o(bus_rd_data),
    .addr_o   (fl_addr_o),
    .dout_o   (fl_dout_o),
    .drv_o    (fl_drv_o),
    .din_i    (fl_din_i),
    .ce_n_o   (fl_ce_n_o),
    .we_n_o   (fl_we_n_o),
    .oe_n_o   (fl_oe_n_o)
  );

  bps_pulse_timer #(
    .PULSE_CYC(PULSE_CYC)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .expired_o(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= T_IDLE;
      launched <= 1'b0;
      a_q      <= '0;
      d_q      <= '0;
      tries    <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (bus_start)     launched <= 1'b1;
      else if (bus_done) launched <= 1'b0;
      case (state)
        T_IDLE: begin
          if (req_valid_i) begin
            a_q    <= req_addr_i;
            d_q    <= req_data_i;
            tries  <= TRY_W'(1);
            err_o  <= 1'b0;
            busy_o <= 1'b1;
            state  <= T_SETUP;
          end
        end
        T_SETUP: if (bus_done) state <= T_PROG;
        T_PROG:  if (bus_done) state <= T_PULSE;
        T_PULSE: if (tmr_expired) state <= T_VCMD;
        T_VCMD:  if (bus_done) state <= T_VREAD;
        T_VREAD: if (bus_done) state <= T_CMP;
        T_CMP: begin
          if (bus_rd_data == d_q) begin
            state  <= T_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else if (tries == TRY_W'(MAX_TRIES)) begin
            state  <= T_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            tries <= tries + 1'b1;
            state <= T_SETUP;
          end
        end
        default: state <= T_IDLE;
      endcase
    end
  end

  assign attempts_o = tries;

  // R10
  target_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(a_q) && $stable(d_q)));

  // R11
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  tries_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tries <= TRY_W'(MAX_TRIES));

  // R7
  err_full_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (tries == TRY_W'(MAX_TRIES)));

  // R6
  pass_match_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> $past(bus_rd_data == d_q));

  // R4
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == T_PULSE) |-> fl_ce_n_o);

endmodule

// File: tb/tb_byte_prog_seq.sv
module tb_byte_prog_seq;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int MAXT  = 25;
  localparam int PULSE = 20;
  localparam int TW    = $clog2(MAXT + 1);
  localparam int NADDR = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          busy, done, err;
  logic [TW-1:0] attempts;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dout, fl_din;
  logic          fl_drv, fl_ce_n, fl_we_n, fl_oe_n;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  byte_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .MAX_TRIES(MAXT), .PULSE_CYC(PULSE),
    .SET_CYC(2), .LOW_CYC(2), .HLD_CYC(1), .RD_CYC(2)
  ) dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_data_i(req_data), .busy_o(busy), .done_o(done), .err_o(err),
    .attempts_o(attempts), .fl_addr_o(fl_addr), .fl_dout_o(fl_dout),
    .fl_drv_o(fl_drv), .fl_din_i(fl_din), .fl_ce_n_o(fl_ce_n),
    .fl_we_n_o(fl_we_n), .fl_oe_n_o(fl_oe_n)
  );

  // Device model: a programmed cell only clears bits (mem &= data), and
  // each address ignores its first stub(a) program pulses.
  logic [DW-1:0] mem [NADDR];
  int            pcnt [NADDR];
  int            cyc = 0;
  int            seq_pos = 0;
  bit            ver_mode = 1'b0;
  logic [AW-1:0] addr_l = '0;
  logic [AW-1:0] prog_a = '0;
  int            fall_cyc = 0, prog_rise = 0, prog_writes = 0;
  int            seq_err = 0, pulse_err = 0, gate_err = 0, hold_err = 0, rel_err = 0;

  function automatic int stub(int a);
    if (a == NADDR - 1) return MAXT - 1;
    return (a * 9) % 29;
  endfunction

  initial for (int i = 0; i < NADDR; i++) begin
    mem[i]  = 8'hFF;
    pcnt[i] = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (fl_oe_n === 1'b0 && fl_drv !== 1'b0) rel_err++;
  end

  always_comb fl_din = ver_mode ? mem[prog_a] : mem[fl_addr];

  always @(negedge fl_we_n) if (fl_ce_n === 1'b0) begin
    addr_l   = fl_addr;
    fall_cyc = cyc;
  end

  always @(posedge fl_we_n) if (fl_ce_n === 1'b0) begin
    if (fl_oe_n !== 1'b1 || fl_drv !== 1'b1) gate_err++;
    if (fl_addr !== addr_l) hold_err++;
    case (seq_pos)
      0: begin
        ver_mode = 1'b0;
        if (fl_dout == 8'h40) seq_pos = 1; else seq_err++;
      end
      1: begin
        if (pcnt[addr_l] >= stub(addr_l)) mem[addr_l] = mem[addr_l] & fl_dout;
        pcnt[addr_l]++;
        prog_a    = addr_l;
        prog_rise = cyc;
        prog_writes++;
        seq_pos = 2;
      end
      default: begin
        if (fl_dout == 8'hC0) begin
          if (fall_cyc - prog_rise < PULSE) pulse_err++;
          ver_mode = 1'b1;
          seq_pos  = 0;
        end else seq_err++;
      end
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int a, input logic [DW-1:0] d, input bit stray);
    int rem, exp_tries, before_stray, wait_n;
    bit exp_err;
    rem = (stub(a) > pcnt[a]) ? stub(a) - pcnt[a] : 0;
    if (rem < MAXT && ((mem[a] & d) == d)) begin
      exp_err = 1'b0;
      exp_tries = rem + 1;
    end else begin
      exp_err = 1'b1;
      exp_tries = MAXT;
    end
    before_stray = pcnt[(a + 6) % NADDR];
    prog_writes = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R11 busy after accept", int'(busy), 1);
    wait_n = 0;
    while (done !== 1'b1 && wait_n < 5000) begin
      if (stray && wait_n == 30) begin
        req_valid = 1'b1; req_addr = AW'((a + 6) % NADDR); req_data = 8'h00;
      end else req_valid = 1'b0;
      @(negedge clk);
      wait_n++;
    end
    req_valid = 1'b0;
    chk(done === 1'b1, "R11 done seen before watchdog", int'(done), 1);
    chk(busy === 1'b0, "R11 busy low with done", int'(busy), 0);
    if (exp_err) begin
      chk(err === 1'b1, "R7 err flag", int'(err), 1);
      chk(attempts == TW'(MAXT), "R7 attempts at limit", int'(attempts), MAXT);
    end else begin
      chk(err === 1'b0, "R6 err flag", int'(err), 0);
      chk(attempts == TW'(exp_tries), "R6 attempts", int'(attempts), exp_tries);
    end
    chk(prog_writes == exp_tries, "R2 program writes per request", prog_writes, exp_tries);
    if (stray)
      chk(pcnt[(a + 6) % NADDR] == before_stray, "R10 stray request ignored",
          pcnt[(a + 6) % NADDR], before_stray);
    @(negedge clk);
    chk(done === 1'b0, "R11 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 status idle",
        int'({busy, done, err}), 0);
    chk(attempts == '0, "R1 attempts zero", int'(attempts), 0);
    chk(fl_ce_n === 1'b1 && fl_we_n === 1'b1 && fl_oe_n === 1'b1 && fl_drv === 1'b0,
        "R1 bus idle", int'({fl_ce_n, fl_we_n, fl_oe_n, fl_drv}), 14);
    rst = 1'b0;
    @(negedge clk);
    // Pass 1: fresh cells, per-address ignored-pulse counts include 0, 24, 25, 27
    for (int a = 0; a < NADDR; a++) do_req(a, DW'((a * 37 + 5) & 8'hFF), a == 3);
    // Pass 2: new bytes; many need a 0 bit back to 1 and cannot verify (R7)
    for (int a = 0; a < NADDR; a++) do_req(a, DW'((a * 53 + 17) & 8'hFF), 1'b0);
    // R7 byte that never verifies on an already programmed cell
    do_req(0, 8'hFF, 1'b0);
    // R6 programming a byte equal to the cell contents succeeds on first try
    do_req(1, mem[1], 1'b0);
    chk(seq_err == 0, "R2 command order", seq_err, 0);
    chk(hold_err == 0, "R3 address held through strobe", hold_err, 0);
    chk(pulse_err == 0, "R4 pulse wait before verify", pulse_err, 0);
    chk(gate_err == 0, "R8 write gating", gate_err, 0);
    chk(rel_err == 0, "R9 driver released in read", rel_err, 0);
    // R5 is covered by every R6/R7 outcome: the compare uses the verify read
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule